// File: doc/BRIEF.md
# Per-CPU Private Interrupt Configuration Register Bank

This block holds the configuration state of 32 private interrupt lines that belong to one CPU, reached over a simple single-cycle register bus. Each request carries an address, write data, an access size (1, 4 or 8 bytes) and a secure attribute. One cycle later the bank returns read data or an error flag. The bank stores group membership, enable, pending and active bitmaps, one priority byte per line, a trigger-mode map, a group-modifier word, a two-bit-per-line non-secure access word, a sleep handshake and two 64-bit base-address registers.

Every access is filtered by security. While security is enabled (`sec_off` low), a non-secure access sees only the lines whose group bit is set. Its bitmap reads return zero for the other lines, and its set/clear writes leave them untouched. Priorities seen by a non-secure access are shifted by one bit and forced into the upper half of the range. A single input, `sec_off`, stands for the system-wide switch that disables security.

The offsets are byte addresses. The 4-byte map is: 0x000 control, 0x004 identity, 0x008/0x00C type (low/high), 0x010 status, 0x014 wake, 0x020/0x024 base A, 0x028/0x02C base B, 0x080 group, 0x100/0x104 enable set/clear, 0x108/0x10C pending set/clear, 0x110/0x114 active set/clear, 0x200–0x21F priority, 0x300/0x304 trigger low/high, 0x380 group modifier, 0x384 non-secure access. Size codes are 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes and 3 = reserved.

Top module: `irq_cfg_bank`

## Requirements
- R1: Every accepted request (`req_valid` high) produces `rsp_valid` high in the next cycle. Write responses and error responses carry zero data. Read data sits in the low bits of `rsp_rdata`.
- R2: An access gets `rsp_err` and changes no state if any of these holds: size code 3; a 4-byte access not 4-aligned; an 8-byte access not 8-aligned; an offset not mapped for that size. Byte access is mapped only at 0x200–0x21F. 8-byte access is mapped only at 0x008, 0x020 and 0x028.
- R3: When security is enabled and the access is non-secure, reads and set/clear writes of the enable, pending and active bitmaps are masked by the group word. Lines whose group bit is 0 read as zero and ignore writes. Otherwise all 32 bits are accessible. A set view ORs the masked data in, and a clear view clears the masked bits.
- R4: The group word reads as zero and ignores writes for a non-secure access while security is enabled. The group-modifier and non-secure-access words read as zero and ignore writes unless the access is secure and security is enabled.
- R5: When security is enabled and the access is non-secure, a priority byte whose line has group bit 0 reads as zero and ignores writes. A permitted read returns the stored byte shifted left by one, truncated to 8 bits. A permitted write stores 0x80 OR the written byte shifted right by one. In every other case the stored byte is read and written unchanged.
- R6: Priority bytes are reached by byte access at 0x200+n and by word access at 0x200+4k. A word access covers lines 4k..4k+3, with line 4k in bits 7:0.
- R7: In the trigger words, line n's mode bit appears at bit 2(n mod 16)+1, with 1 meaning edge. Word 0x300 covers lines 0–15 and ignores writes. Word 0x304 covers lines 16–31 and is writable under the R3 group mask. Reads are masked the same way. At reset lines 0–15 are edge and lines 16–31 are level.
- R8: Reads of either pending view return the pending latch OR (`line_level` AND NOT edge-mode), masked as in R3.
- R9: In the wake word only bit 0 (sleep request) is writable. A write sets bit 1 (children asleep) to the same value in the same cycle. The other bits read as zero.
- R10: The control word reads 0x0 and the status word reads 0. The identity word reads 0x00010A5C. The type register reads 0x00000001_00000010. Writes to these four have no effect and no error.
- R11: Each base register accepts an 8-byte access, or a 4-byte access to either half, for read and write. A half write leaves the other half unchanged. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_off | input | 1 | Security disabled for the whole system |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset within the bank |
| req_size | input | 2 | 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes, 3 = reserved |
| req_wdata | input | 64 | Write data, low-aligned |
| req_secure | input | 1 | Secure attribute of the access |
| line_level | input | 32 | Raw level of each private interrupt line |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Read data |

## Verification
The hardest state to reach from the ports mixes three things on the same lines: partial group membership, a non-secure access, and level-triggered lines whose raw input is high. The pending read path and the trigger-mode mask only interact there. The stimulus first writes a mixed group word and a new trigger map through secure accesses. It then raises selected lines and reads the pending views as secure and as non-secure. Finally it flips `sec_off` and repeats the masked accesses, so that the same bits are seen through every mask.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  typedef enum logic [4:0] {
    RG_CTRL, RG_IDENT, RG_TYPE, RG_STAT, RG_WAKE, RG_BASEA, RG_BASEB,
    RG_GROUP, RG_ENS, RG_ENC, RG_PDS, RG_PDC, RG_ACS, RG_ACC,
    RG_PRIO, RG_TRIG0, RG_TRIG1, RG_GMOD, RG_NSAC, RG_NONE
  } reg_e;

  // one mode bit per line placed in the odd bit positions
  function automatic logic [31:0] odd_spread(input logic [15:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) r[2*i+1] = v[i];
    return r;
  endfunction

  function automatic logic [15:0] odd_gather(input logic [31:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[2*i+1];
    return r;
  endfunction

  // non-secure view of a priority byte
  function automatic logic [7:0] prio_ns_read(input logic [7:0] stored);
    return {stored[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] prio_ns_write(input logic [7:0] written);
    return {1'b1, written[7:1]};
  endfunction

  function automatic logic [63:0] pick_half(input logic [63:0] v, input logic full,
                                             input logic hi);
    if (full) return v;
    return hi ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
  endfunction

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
  import irqb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output reg_e          sel,
  output logic          hi,
  output logic          misal,
  output logic          bad
);
  localparam logic [AW-1:0] PRIO_LO = AW'('h200);
  localparam logic [AW-1:0] PRIO_HI = AW'('h220);

  logic in_prio;
  assign in_prio = (addr >= PRIO_LO) && (addr < PRIO_HI);
  assign misal   = (size == 2'd1 && addr[1:0] != 2'b00) ||
                   (size == 2'd2 && addr[2:0] != 3'b000);

  always_comb begin
    sel = RG_NONE;
    hi  = 1'b0;
    unique case (size)
      2'd0: if (in_prio) sel = RG_PRIO;
      2'd1: begin
        unique case (addr)
          AW'('h000): sel = RG_CTRL;
          AW'('h004): sel = RG_IDENT;
          AW'('h008): sel = RG_TYPE;
          AW'('h00C): begin sel = RG_TYPE;  hi = 1'b1; end
          AW'('h010): sel = RG_STAT;
          AW'('h014): sel = RG_WAKE;
          AW'('h020): sel = RG_BASEA;
          AW'('h024): begin sel = RG_BASEA; hi = 1'b1; end
          AW'('h028): sel = RG_BASEB;
          AW'('h02C): begin sel = RG_BASEB; hi = 1'b1; end
          AW'('h080): sel = RG_GROUP;
          AW'('h100): sel = RG_ENS;
          AW'('h104): sel = RG_ENC;
          AW'('h108): sel = RG_PDS;
          AW'('h10C): sel = RG_PDC;
          AW'('h110): sel = RG_ACS;
          AW'('h114): sel = RG_ACC;
          AW'('h300): sel = RG_TRIG0;
          AW'('h304): sel = RG_TRIG1;
          AW'('h380): sel = RG_GMOD;
          AW'('h384): sel = RG_NSAC;
          default:    if (in_prio) sel = RG_PRIO;
        endcase
      end
      2'd2: begin
        unique case (addr)
          AW'('h008): sel = RG_TYPE;
          AW'('h020): sel = RG_BASEA;
          AW'('h028): sel = RG_BASEB;
          default:    sel = RG_NONE;
        endcase
      end
      default: sel = RG_NONE;
    endcase
  end

  assign bad = misal || (sel == RG_NONE);
endmodule

// File: rtl/irqb_prio.sv
module irqb_prio
  import irqb_pkg::*;
#(
  parameter int NIRQ = 32,
  localparam int IW  = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic            wide,
  input  logic [31:0]     wdata,
  input  logic            ns_view,
  input  logic [NIRQ-1:0] grp,
  output logic [31:0]     rdata
);
  logic [7:0] pr_q [NIRQ];

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    logic [IW:0] lane;
    logic        hit;
    logic [7:0]  wbyte;
    assign lane  = (IW+1)'(i) - {1'b0, idx};
    assign hit   = we && (wide ? (lane < (IW+1)'(4)) : (lane == '0)) &&
                   (!ns_view || grp[i]);
    assign wbyte = wdata[8*lane[1:0] +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pr_q[i] <= '0;
      else if (hit) pr_q[i] <= ns_view ? prio_ns_write(wbyte) : wbyte;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [IW-1:0] j;
    assign j = idx + IW'(k);
    always_comb begin
      if ((k > 0 && !wide) || (ns_view && !grp[j])) rdata[8*k +: 8] = 8'h00;
      else if (ns_view)                            rdata[8*k +: 8] = prio_ns_read(pr_q[j]);
      else                                         rdata[8*k +: 8] = pr_q[j];
    end
  end
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irqb_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [31:0] CTRL_RST  = 32'h0000_0000,
  parameter logic [31:0] IDENT_VAL = 32'h0001_0A5C,
  parameter logic [63:0] TYPE_VAL  = 64'h0000_0001_0000_0010,
  parameter logic [31:0] EDGE_RST  = 32'h0000_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_off,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [63:0]   req_wdata,
  input  logic          req_secure,
  input  logic [31:0]   line_level,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [63:0]   rsp_rdata
);
  localparam int NIRQ = 32;
  localparam int HALF = NIRQ / 2;

  reg_e        sel;
  logic        hi, misal, bad;
  logic [31:0] group_q, en_q, pend_q, act_q, edge_q, gmod_q, nsac_q;
  logic [1:0]  wake_q;
  logic [63:0] basea_q, baseb_q;
  logic [31:0] prio_rd;

  // named events used by the checker
  logic        ns_gate, sec_priv, do_wr, full;
  logic [31:0] vis_mask, wd32, pend_view;
  logic [63:0] rd64;

  irqb_decode #(.AW(AW)) u_dec (
    .addr(req_addr), .size(req_size), .sel(sel), .hi(hi), .misal(misal), .bad(bad)
  );

  assign ns_gate   = !req_secure && !sec_off;
  assign sec_priv  = req_secure && !sec_off;
  assign vis_mask  = ns_gate ? group_q : '1;
  assign do_wr     = req_valid && req_write && !bad;
  assign wd32      = req_wdata[31:0];
  assign full      = (req_size == 2'd2);
  assign pend_view = pend_q | (line_level & ~edge_q);

  irqb_prio #(.NIRQ(NIRQ)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .we(do_wr && sel == RG_PRIO), .idx(req_addr[4:0]),
    .wide(req_size == 2'd1), .wdata(wd32), .ns_view(ns_gate),
    .grp(group_q), .rdata(prio_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      group_q <= '0; en_q <= '0; pend_q <= '0; act_q <= '0;
      edge_q  <= EDGE_RST; gmod_q <= '0; nsac_q <= '0; wake_q <= '0;
      basea_q <= '0; baseb_q <= '0;
    end else if (do_wr) begin
      unique case (sel)
        RG_GROUP: if (!ns_gate) group_q <= wd32;
        RG_ENS:   en_q   <= en_q   |  (wd32 & vis_mask);
        RG_ENC:   en_q   <= en_q   & ~(wd32 & vis_mask);
        RG_PDS:   pend_q <= pend_q |  (wd32 & vis_mask);
        RG_PDC:   pend_q <= pend_q & ~(wd32 & vis_mask);
        RG_ACS:   act_q  <= act_q  |  (wd32 & vis_mask);
        RG_ACC:   act_q  <= act_q  & ~(wd32 & vis_mask);
        RG_TRIG1: edge_q[NIRQ-1:HALF] <= (edge_q[NIRQ-1:HALF] & ~vis_mask[NIRQ-1:HALF]) |
                                         (odd_gather(wd32) & vis_mask[NIRQ-1:HALF]);
        RG_GMOD:  if (sec_priv) gmod_q <= wd32;
        RG_NSAC:  if (sec_priv) nsac_q <= wd32;
        RG_WAKE:  wake_q <= {2{wd32[0]}};
        RG_BASEA: if (full) basea_q <= req_wdata;
                  else if (hi) basea_q[63:32] <= wd32;
                  else basea_q[31:0] <= wd32;
        RG_BASEB: if (full) baseb_q <= req_wdata;
                  else if (hi) baseb_q[63:32] <= wd32;
                  else baseb_q[31:0] <= wd32;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd64 = '0;
    unique case (sel)
      RG_CTRL:  rd64[31:0] = CTRL_RST;
      RG_IDENT: rd64[31:0] = IDENT_VAL;
      RG_TYPE:  rd64 = pick_half(TYPE_VAL, full, hi);
      RG_WAKE:  rd64[1:0] = wake_q;
      RG_BASEA: rd64 = pick_half(basea_q, full, hi);
      RG_BASEB: rd64 = pick_half(baseb_q, full, hi);
      RG_GROUP: rd64[31:0] = ns_gate ? '0 : group_q;
      RG_ENS, RG_ENC: rd64[31:0] = en_q & vis_mask;
      RG_PDS, RG_PDC: rd64[31:0] = pend_view & vis_mask;
      RG_ACS, RG_ACC: rd64[31:0] = act_q & vis_mask;
      RG_PRIO:  rd64[31:0] = prio_rd;
      RG_TRIG0: rd64[31:0] = odd_spread(edge_q[HALF-1:0] & vis_mask[HALF-1:0]);
      RG_TRIG1: rd64[31:0] = odd_spread(edge_q[NIRQ-1:HALF] & vis_mask[NIRQ-1:HALF]);
      RG_GMOD:  rd64[31:0] = sec_priv ? gmod_q : '0;
      RG_NSAC:  rd64[31:0] = sec_priv ? nsac_q : '0;
      default:  rd64 = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (req_valid && !bad && !req_write) ? rd64 : '0;
    end
  end
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [63:0] req_wdata,
  input logic        bad,
  input logic        ns_gate,
  input logic        sel_group,
  input logic        sel_wake,
  input logic [31:0] group_q,
  input logic [31:0] en_q,
  input logic [1:0]  wake_q,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_rdata
);
  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_write_zero_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_rdata == 64'h0);

  assert_bad_flags_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad) |=> rsp_err);

  assert_bad_keeps_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad) |=> $stable(en_q));

  assert_ns_group_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && ns_gate && sel_group) |=> $stable(group_q));

  assert_wake_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !bad && sel_wake) |=> wake_q == {2{$past(req_wdata[0])}});
endmodule

bind irq_cfg_bank irqb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wdata(req_wdata), .bad(bad), .ns_gate(ns_gate),
  .sel_group(sel == irqb_pkg::RG_GROUP), .sel_wake(sel == irqb_pkg::RG_WAKE),
  .group_q(group_q), .en_q(en_q), .wake_q(wake_q),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/irq_cfg_bank_tb.sv
`timescale 1ns/1ps
module irq_cfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_off = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [31:0] line_level = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_cfg_bank dut_i (.*);

  // behavioural reference state
  logic [31:0] m_grp, m_en, m_pd, m_ac, m_edge, m_gm, m_ns;
  logic [1:0]  m_wake;
  logic [63:0] m_ba, m_bb;
  logic [7:0]  m_pr [32];

  task automatic model_reset();
    m_grp = 0; m_en = 0; m_pd = 0; m_ac = 0; m_edge = 32'h0000_FFFF;
    m_gm = 0; m_ns = 0; m_wake = 0; m_ba = 0; m_bb = 0;
    foreach (m_pr[i]) m_pr[i] = 0;
  endtask

  function automatic logic [7:0] pr_lane(int i, bit w, logic [7:0] v, bit ns);
    logic [7:0] t;
    if (ns && !m_grp[i]) return 8'h00;
    if (w) begin
      m_pr[i] = ns ? (8'h80 | (v >> 1)) : v;
      return 8'h00;
    end
    t = m_pr[i] << 1;
    return ns ? t : m_pr[i];
  endfunction

  function automatic logic [63:0] half64(logic [63:0] v, logic [1:0] sz, bit up);
    if (sz == 2) return v;
    return up ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
  endfunction

  task automatic model(input bit w, input logic [15:0] a, input logic [1:0] sz,
                       input logic [63:0] d, input bit s,
                       output bit e, output logic [63:0] r);
    bit ns, priv;
    logic [31:0] mk;
    ns = !s && !sec_off;
    priv = s && !sec_off;
    mk = ns ? m_grp : 32'hFFFF_FFFF;
    e = 0; r = 0;
    if (sz == 3 || (sz == 1 && a[1:0] != 0) || (sz == 2 && a[2:0] != 0)) begin e = 1; return; end
    if (sz == 0) begin
      if (a >= 16'h200 && a < 16'h220) r[7:0] = pr_lane(a - 16'h200, w, d[7:0], ns);
      else e = 1;
    end else if (sz == 2) begin
      if (a == 16'h008) r = 64'h0000_0001_0000_0010;
      else if (a == 16'h020) begin r = m_ba; if (w) m_ba = d; end
      else if (a == 16'h028) begin r = m_bb; if (w) m_bb = d; end
      else e = 1;
    end else begin
      if (a >= 16'h200 && a < 16'h220) begin
        for (int k = 0; k < 4; k++) r[8*k +: 8] = pr_lane(a - 16'h200 + k, w, d[8*k +: 8], ns);
      end else if (a == 16'h000 || a == 16'h010) r = 0;
      else if (a == 16'h004) r = 32'h0001_0A5C;
      else if (a == 16'h008 || a == 16'h00C) r = half64(64'h0000_0001_0000_0010, sz, a[2]);
      else if (a == 16'h014) begin r = m_wake; if (w) m_wake = {2{d[0]}}; end
      else if (a[15:4] == 12'h002) begin
        if (a[3]) begin r = half64(m_bb, sz, a[2]); if (w) begin if (a[2]) m_bb[63:32] = d[31:0]; else m_bb[31:0] = d[31:0]; end end
        else      begin r = half64(m_ba, sz, a[2]); if (w) begin if (a[2]) m_ba[63:32] = d[31:0]; else m_ba[31:0] = d[31:0]; end end
      end else if (a == 16'h080) begin r = ns ? 0 : m_grp; if (w && !ns) m_grp = d[31:0]; end
      else if (a == 16'h100 || a == 16'h104) begin r = m_en & mk;
        if (w) m_en = a[2] ? (m_en & ~(d[31:0] & mk)) : (m_en | (d[31:0] & mk)); end
      else if (a == 16'h108 || a == 16'h10C) begin r = (m_pd | (line_level & ~m_edge)) & mk;
        if (w) m_pd = a[2] ? (m_pd & ~(d[31:0] & mk)) : (m_pd | (d[31:0] & mk)); end
      else if (a == 16'h110 || a == 16'h114) begin r = m_ac & mk;
        if (w) m_ac = a[2] ? (m_ac & ~(d[31:0] & mk)) : (m_ac | (d[31:0] & mk)); end
      else if (a == 16'h300 || a == 16'h304) begin
        int b = a[2] ? 16 : 0;
        for (int i = 0; i < 16; i++) r[2*i+1] = m_edge[b+i] & mk[b+i];
        if (w && a[2])
          for (int i = 0; i < 16; i++) if (mk[16+i]) m_edge[16+i] = d[2*i+1];
      end else if (a == 16'h380) begin r = priv ? m_gm : 0; if (w && priv) m_gm = d[31:0]; end
      else if (a == 16'h384) begin r = priv ? m_ns : 0; if (w && priv) m_ns = d[31:0]; end
      else e = 1;
    end
    if (w || e) r = 0;
  endtask

  // one bus access: drive at a falling edge, compare at the next falling edge
  task automatic acc(input bit w, input logic [15:0] a, input logic [1:0] sz,
                     input logic [63:0] d, input bit s, input string tag);
    bit ee;
    logic [63:0] er;
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = d; req_secure = s;
    model(w, a, sz, d, s, ee, er);
    @(negedge clk);
    req_valid = 0;
    n_cmp++;
    if (rsp_valid !== 1'b1 || rsp_err !== ee || rsp_rdata !== er) begin
      n_bad++;
      $display("FAIL %s addr=%h: got v=%b e=%b d=%h, exp v=1 e=%b d=%h",
               tag, a, rsp_valid, rsp_err, rsp_rdata, ee, er);
    end
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
      n_bad++;
      $display("FAIL %s idle: got v=%b e=%b, exp v=0 e=0", tag, rsp_valid, rsp_err);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hang, exp completion");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 reset");
    // R10 fixed words and R7 reset trigger map
    acc(0, 16'h000, 1, 0, 1, "R10 ctrl");
    acc(1, 16'h004, 1, 64'hFFFF, 1, "R10 ident write");
    acc(0, 16'h004, 1, 0, 0, "R10 ident");
    acc(0, 16'h008, 2, 0, 1, "R10 type 64");
    acc(0, 16'h00C, 1, 0, 1, "R10 type hi");
    acc(1, 16'h010, 1, 64'hFFFF_FFFF, 1, "R10 status write");
    acc(0, 16'h010, 1, 0, 1, "R10 status");
    acc(0, 16'h300, 1, 0, 1, "R7 trig0 reset");
    // R4 group word: secure write, non-secure blocked
    acc(1, 16'h080, 1, 64'h0000_FF0F, 1, "R4 group set");
    acc(1, 16'h080, 1, 64'hFFFF_FFFF, 0, "R4 ns group write");
    acc(0, 16'h080, 1, 0, 0, "R4 ns group read");
    acc(0, 16'h080, 1, 0, 1, "R4 group read");
    // R3 masked bitmaps
    acc(1, 16'h100, 1, 64'hFFFF_FFFF, 0, "R3 ns enable set");
    acc(0, 16'h100, 1, 0, 1, "R3 enable secure view");
    acc(1, 16'h104, 1, 64'h0000_00FF, 0, "R3 ns enable clear");
    acc(0, 16'h104, 1, 0, 0, "R3 ns enable view");
    acc(1, 16'h110, 1, 64'hF0F0_F0F0, 1, "R3 active set");
    acc(0, 16'h110, 1, 0, 0, "R3 ns active view");
    acc(1, 16'h114, 1, 64'hFFFF_FFFF, 0, "R3 ns active clear");
    acc(0, 16'h114, 1, 0, 1, "R3 active after clear");
    // R5/R6 priority
    acc(1, 16'h200, 1, 64'h4433_2211, 1, "R6 prio word write");
    acc(0, 16'h201, 0, 0, 1, "R6 prio byte 1");
    acc(0, 16'h200, 0, 0, 0, "R5 ns prio read");
    acc(1, 16'h204, 0, 64'h77, 0, "R5 ns write blocked line");
    acc(1, 16'h208, 0, 64'h40, 0, "R5 ns prio write");
    acc(1, 16'h20C, 1, 64'hFFEE_DDCC, 0, "R5 ns word write");
    acc(0, 16'h208, 1, 0, 1, "R6 prio word read");
    acc(0, 16'h20C, 1, 0, 0, "R5 ns word read");
    acc(0, 16'h204, 1, 0, 1, "R5 blocked line unchanged");
    acc(0, 16'h21C, 1, 0, 0, "R5 ns top word");
    // R7 trigger map
    acc(1, 16'h300, 1, 64'h0, 1, "R7 trig0 ignored");
    acc(0, 16'h300, 1, 0, 1, "R7 trig0 read");
    acc(1, 16'h304, 1, 64'h0000_000A, 1, "R7 trig1 write");
    acc(0, 16'h304, 1, 0, 1, "R7 trig1 read");
    acc(1, 16'h080, 1, 64'h0003_FF0F, 1, "R7 widen group");
    acc(1, 16'h304, 1, 64'hAAAA_AAAA, 0, "R7 ns trig1 write");
    acc(0, 16'h304, 1, 0, 1, "R7 trig1 after ns");
    acc(0, 16'h304, 1, 0, 0, "R7 ns trig1 view");
    // R8 pending with level lines
    line_level = 32'hA5A5_5A5A;
    acc(0, 16'h108, 1, 0, 1, "R8 pending level");
    acc(1, 16'h108, 1, 64'h0000_0030, 1, "R8 pending set");
    acc(0, 16'h10C, 1, 0, 0, "R8 ns pending view");
    acc(1, 16'h10C, 1, 64'hFFFF_FFFF, 0, "R8 ns pending clear");
    acc(0, 16'h108, 1, 0, 1, "R8 pending after clear");
    line_level = 32'h0;
    acc(0, 16'h108, 1, 0, 1, "R8 pending latch only");
    // R4 modifier / access words
    acc(1, 16'h380, 1, 64'h1234_5678, 1, "R4 gmod write");
    acc(0, 16'h380, 1, 0, 0, "R4 ns gmod read");
    acc(1, 16'h384, 1, 64'h5555_AAAA, 0, "R4 ns nsac write");
    acc(0, 16'h384, 1, 0, 1, "R4 nsac read");
    acc(1, 16'h384, 1, 64'h0000_00F3, 1, "R4 nsac write");
    sec_off = 1;
    acc(0, 16'h380, 1, 0, 1, "R4 gmod secoff");
    acc(1, 16'h380, 1, 64'hFFFF_FFFF, 1, "R4 gmod secoff write");
    acc(1, 16'h100, 1, 64'h0F00_0000, 0, "R3 secoff enable set");
    acc(0, 16'h100, 1, 0, 0, "R3 secoff enable view");
    acc(0, 16'h204, 0, 0, 0, "R5 secoff prio byte");
    acc(1, 16'h080, 1, 64'h0000_0001, 0, "R4 secoff group write");
    sec_off = 0;
    acc(0, 16'h380, 1, 0, 1, "R4 gmod kept");
    acc(0, 16'h384, 1, 0, 1, "R4 nsac kept");
    acc(0, 16'h100, 1, 0, 0, "R3 ns enable narrow group");
    // R9 wake
    acc(1, 16'h014, 1, 64'hFFFF_FFFF, 0, "R9 wake sleep");
    acc(0, 16'h014, 1, 0, 1, "R9 wake read");
    acc(1, 16'h014, 1, 64'hFFFF_FFFE, 1, "R9 wake clear");
    acc(0, 16'h014, 1, 0, 0, "R9 wake read 0");
    // R11 base registers
    acc(1, 16'h020, 2, 64'h0123_4567_89AB_CDEF, 1, "R11 base A 64");
    acc(1, 16'h024, 1, 64'hDEAD_BEEF, 1, "R11 base A hi");
    acc(0, 16'h020, 2, 0, 1, "R11 base A read");
    acc(0, 16'h020, 1, 0, 0, "R11 base A lo");
    acc(1, 16'h028, 1, 64'h1111_2222, 1, "R11 base B lo");
    acc(1, 16'h02C, 1, 64'h3333_4444, 1, "R11 base B hi");
    acc(0, 16'h028, 2, 0, 1, "R11 base B read");
    acc(1, 16'h008, 2, 64'hFFFF, 1, "R10 type 64 write");
    acc(0, 16'h008, 1, 0, 1, "R10 type lo");
    // R2 errors
    acc(1, 16'h102, 1, 64'hFFFF_FFFF, 1, "R2 misaligned word");
    acc(1, 16'h024, 2, 64'hFFFF, 1, "R2 misaligned dword");
    acc(0, 16'h100, 3, 0, 1, "R2 reserved size");
    acc(1, 16'h100, 0, 64'hFF, 1, "R2 byte to bitmap");
    acc(0, 16'h080, 2, 0, 1, "R2 dword to group");
    acc(0, 16'h400, 1, 0, 1, "R2 unmapped");
    acc(1, 16'h220, 0, 64'hFF, 1, "R2 past prio");
    acc(0, 16'h100, 1, 0, 1, "R2 enable unchanged");
    idle("R1 idle after");
    summary();
  end
endmodule